// File: doc/BRIEF.md
# Selectable-Length Timer Counter

This block is the counting core of a general-purpose timer. It advances once for every clock cycle in which the tick enable is high. It can act as an 8-, 10-, 12- or 16-bit counter, and the length is chosen at run time. A two-bit mode selects one of four behaviours: stopped, up to a period value, free running to the length maximum, or a triangle that rises to the period value and falls back to zero.

Software can load the count through a write strobe. It can zero the count and the direction with a clear strobe. It can release the sticky wrap flag with a write-one-to-clear strobe. In the up and up/down modes, a period of zero parks the counter at zero. Loading a nonzero period releases it, and counting restarts upward from zero.

Top module: `vlt_timer`

## Requirements
- R1: Length code 0, 1, 2 and 3 selects 8, 10, 12 and 16 bits, giving maximum counts 0xFF, 0x3FF, 0xFFF and 0xFFFF. In continuous mode (mode 2), the count runs up to the selected maximum, wraps to 0 on the next tick and sets the flag.
- R2: A write strobe loads the write data masked to the selected length, so bits above it are zero. The value appears on the count at the next clock edge, and a tick in the same cycle is overridden.
- R3: Clear has the highest priority. It makes the count 0 and the direction up (dir_down_o = 0) at the next edge, even if a write comes in the same cycle.
- R4: The count changes only when the mode is nonzero and the tick is high. Mode 0 is stop. With the tick low, or in mode 0, the count holds.
- R5: In up mode (1) or up/down mode (3), a period value that is zero within the selected length parks the block. The count is forced to 0 and the direction to up, and writes are ignored.
- R6: After a park, a nonzero period makes the counter start from 0 and count upward.
- R7: In up mode, the count goes 0, 1, ... up to the period value P, then wraps to 0 and sets the flag. A count already above P also wraps to 0 on the next tick.
- R8: In up/down mode, the count rises to P and then falls to 0, for a round trip of 2P ticks. dir_down_o is 1 while the count is falling and stays 1 at the zero it reached. The flag is set when the count reaches 0 going down. In other modes dir_down_o is 0.
- R9: The overflow flag is sticky. An ovf_clr_i pulse clears it, and a new wrap in the same cycle as the pulse keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count qualifier, one step per high cycle |
| mode_i | input | 2 | 0 stop, 1 up, 2 continuous, 3 up/down |
| len_sel_i | input | 2 | Length code: 0=8, 1=10, 2=12, 3=16 bits |
| clr_i | input | 1 | Clear count and direction |
| period_i | input | 16 | Period compare value |
| wr_en_i | input | 1 | Software count write strobe |
| wr_data_i | input | 16 | Software count write data |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| count_o | output | 16 | Current count |
| dir_down_o | output | 1 | 1 while counting down in up/down mode |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
In up mode, the bench sweeps several periods and checks every tick against n mod (P+1). This catches off-by-one wrap points and a missing or early flag. The up/down sweeps use both odd and even periods and compare the count and direction to a closed-form triangle, which shows whether the turn happens at P and at zero. Continuous runs start just below each length's maximum, and a full 8-bit sweep shows that the length mask sets the wrap point. Directed patterns then cover stop, a low tick, parking and restart, writes above the length, a count above the period, the clear and write priorities, and a flag clear that coincides with a wrap.

// File: rtl/vlt_pkg.sv
package vlt_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    LEN_8  = 2'd0,
    LEN_10 = 2'd1,
    LEN_12 = 2'd2,
    LEN_16 = 2'd3
  } len_e;
endpackage

// File: rtl/vlt_next.sv
module vlt_next #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             dir_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       len_sel_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] mask_o,
  output logic [CNT_W-1:0] nx_count_o,
  output logic             nx_dir_o,
  output logic             park_o,
  output logic             adv_o,
  output logic             wrap_o
);
  import vlt_pkg::*;

  localparam int BASE_W = 8;

  function automatic int len_bits(input logic [1:0] sel);
    int b;
    b = (sel == LEN_16) ? 16 : BASE_W + 2 * int'(sel);
    return (b > CNT_W) ? CNT_W : b;
  endfunction

  function automatic logic [CNT_W-1:0] len_mask(input logic [1:0] sel);
    logic [CNT_W-1:0] m;
    for (int i = 0; i < CNT_W; i++) m[i] = (i < len_bits(sel));
    return m;
  endfunction

  mode_e            mode_w;
  logic [CNT_W-1:0] per_w;
  logic [CNT_W-1:0] one_w;

  assign mode_w = mode_e'(mode_i);
  assign mask_o = len_mask(len_sel_i);
  assign per_w  = period_i & mask_o;
  assign one_w  = {{(CNT_W-1){1'b0}}, 1'b1};
  assign park_o = ((mode_w == MODE_UP) || (mode_w == MODE_UPDN)) && (per_w == '0);
  assign adv_o  = tick_i && (mode_w != MODE_STOP) && !park_o;

  always_comb begin
    nx_count_o = count_i;
    nx_dir_o   = (mode_w == MODE_UPDN) ? dir_i : 1'b0;
    wrap_o     = 1'b0;
    if (adv_o) begin
      unique case (mode_w)
        MODE_UP: begin
          if (count_i >= per_w) begin
            nx_count_o = '0;
            wrap_o     = 1'b1;
          end else begin
            nx_count_o = count_i + one_w;
          end
        end
        MODE_CONT: begin
          if (count_i >= mask_o) begin
            nx_count_o = '0;
            wrap_o     = 1'b1;
          end else begin
            nx_count_o = count_i + one_w;
          end
        end
        MODE_UPDN: begin
          if (!dir_i) begin
            if (count_i >= per_w) begin
              nx_dir_o   = 1'b1;
              nx_count_o = count_i - one_w;
              wrap_o     = (count_i == one_w);
            end else begin
              nx_count_o = count_i + one_w;
            end
          end else if (count_i == '0) begin
            nx_dir_o   = 1'b0;
            nx_count_o = one_w;
          end else begin
            nx_count_o = count_i - one_w;
            wrap_o     = (count_i == one_w);
          end
        end
        default: nx_count_o = count_i;
      endcase
    end
  end
endmodule

// File: rtl/vlt_flag.sv
module vlt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R9: sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  // R9: a wrap always leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
endmodule

// File: rtl/vlt_timer.sv
module vlt_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       len_sel_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             ovf_o
);
  import vlt_pkg::*;

  logic [CNT_W-1:0] count_q;
  logic             dir_q;
  logic [CNT_W-1:0] mask_w;
  logic [CNT_W-1:0] nx_count_w;
  logic             nx_dir_w;
  logic             park_w;
  logic             adv_w;
  logic             wrap_w;
  logic             ovf_set_w;

  vlt_next #(.CNT_W(CNT_W)) next_i (
    .count_i    (count_q),
    .dir_i      (dir_q),
    .mode_i     (mode_i),
    .len_sel_i  (len_sel_i),
    .period_i   (period_i),
    .tick_i     (tick_i),
    .mask_o     (mask_w),
    .nx_count_o (nx_count_w),
    .nx_dir_o   (nx_dir_w),
    .park_o     (park_w),
    .adv_o      (adv_w),
    .wrap_o     (wrap_w)
  );

  // Priority: clear, park, software write, counting step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      dir_q   <= 1'b0;
    end else if (clr_i || park_w) begin
      count_q <= '0;
      dir_q   <= 1'b0;
    end else if (wr_en_i) begin
      count_q <= wr_data_i & mask_w;
      dir_q   <= (mode_e'(mode_i) == MODE_UPDN) ? dir_q : 1'b0;
    end else begin
      count_q <= nx_count_w;
      dir_q   <= nx_dir_w;
    end
  end

  assign ovf_set_w = wrap_w && !clr_i && !park_w && !wr_en_i;

  vlt_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovf_set_w),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_o)
  );

  assign count_o    = count_q;
  assign dir_down_o = dir_q;

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0) && !dir_down_o);
  a_r2_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_i && !park_w) |=> count_o == $past(wr_data_i & mask_w));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !wr_en_i && !park_w && (!tick_i || mode_i == 2'd0)) |=> $stable(count_o));
  a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
    park_w |=> (count_o == '0) && !dir_down_o);
  a_r8_dir_only_updn: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd3) |=> !dir_down_o);
  a_r1_within_length: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_w && !clr_i && !wr_en_i && mode_i == 2'd2 && $stable(len_sel_i)) |=>
      ((count_o & ~mask_w) == '0));
endmodule

// File: tb/vlt_timer_tb_top.sv
module vlt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [1:0]  len_sel_i = 2'd3;
  logic        clr_i = 1'b0;
  logic [15:0] period_i = 16'd0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = 16'd0;
  logic        ovf_clr_i = 1'b0;
  logic [15:0] count_o;
  logic        dir_down_o;
  logic        ovf_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  vlt_timer #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i),
    .len_sel_i(len_sel_i), .clr_i(clr_i), .period_i(period_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .ovf_clr_i(ovf_clr_i),
    .count_o(count_o), .dir_down_o(dir_down_o), .ovf_o(ovf_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      cycle();
    end
    tick_i = 1'b0;
  endtask

  task automatic do_clear();
    clr_i = 1'b1; cycle(); clr_i = 1'b0;
  endtask

  task automatic flag_clear();
    ovf_clr_i = 1'b1; cycle(); ovf_clr_i = 1'b0;
  endtask

  task automatic wr(input logic [15:0] v);
    wr_en_i = 1'b1; wr_data_i = v; cycle(); wr_en_i = 1'b0;
  endtask

  function automatic int maxof(input int sel);
    return (sel == 3) ? 65535 : (1 << (8 + 2 * sel)) - 1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycle();
    chk("R3 reset count", count_o, 0);
    chk("R3 reset dir", dir_down_o, 0);
    chk("R9 reset flag", ovf_o, 0);

    // R2: masked writes per length
    for (int l = 0; l < 4; l++) begin
      len_sel_i = l[1:0];
      wr(16'hFFFF);
      chk("R2 write all ones", count_o, maxof(l));
      wr(16'hA5C3);
      chk("R2 write pattern", count_o, 16'hA5C3 & maxof(l));
    end

    // R1: continuous wrap for each length
    for (int l = 0; l < 4; l++) begin
      mode_i = 2'd0; len_sel_i = l[1:0];
      wr(16'(maxof(l) - 2));
      flag_clear();
      mode_i = 2'd2;
      ticks(2);
      chk("R1 reach max", count_o, maxof(l));
      chk("R1 no flag before wrap", ovf_o, 0);
      ticks(1);
      chk("R1 wrap to zero", count_o, 0);
      chk("R1 flag on wrap", ovf_o, 1);
    end

    // R1: full 8-bit continuous sweep
    mode_i = 2'd0; len_sel_i = 2'd0; do_clear(); flag_clear(); mode_i = 2'd2;
    for (int n = 1; n <= 300; n++) begin
      ticks(1);
      chk("R1 sweep count", count_o, n % 256);
      chk("R1 sweep flag", ovf_o, (n >= 256) ? 1 : 0);
    end

    // R7: up mode sweeps
    len_sel_i = 2'd3;
    foreach (period_set[k]) begin
      int p;
      p = period_set[k];
      mode_i = 2'd0; period_i = 16'(p); do_clear(); flag_clear(); mode_i = 2'd1;
      for (int n = 1; n <= 2 * p + 3; n++) begin
        ticks(1);
        chk("R7 up count", count_o, n % (p + 1));
        chk("R7 up flag", ovf_o, (n >= p + 1) ? 1 : 0);
      end
    end

    // R8: up/down sweeps
    foreach (tri_set[k]) begin
      int p;
      p = tri_set[k];
      mode_i = 2'd0; period_i = 16'(p); do_clear(); flag_clear(); mode_i = 2'd3;
      for (int n = 1; n <= 3 * p + 2; n++) begin
        int m;
        m = n % (2 * p);
        ticks(1);
        chk("R8 updn count", count_o, (m <= p) ? m : 2 * p - m);
        chk("R8 updn dir", dir_down_o, ((m > p) || (m == 0)) ? 1 : 0);
        chk("R8 updn flag", ovf_o, (n >= 2 * p) ? 1 : 0);
      end
    end
    mode_i = 2'd1; cycle();
    chk("R8 dir cleared outside updn", dir_down_o, 0);

    // R4: stop mode and low tick
    mode_i = 2'd0; wr(16'd5); ticks(4);
    chk("R4 stop holds", count_o, 5);
    mode_i = 2'd1; period_i = 16'd9; do_clear(); repeat (3) cycle();
    chk("R4 no tick holds", count_o, 0);
    ticks(2);
    chk("R4 tick advances", count_o, 2);

    // R5/R6: park and restart
    mode_i = 2'd0; wr(16'd7); period_i = 16'd0; mode_i = 2'd1; cycle();
    chk("R5 park zeroes", count_o, 0);
    ticks(3);
    chk("R5 park holds", count_o, 0);
    wr(16'd9);
    chk("R5 write ignored while parked", count_o, 0);
    period_i = 16'd4; ticks(2);
    chk("R6 restart up from zero", count_o, 2);
    mode_i = 2'd0; period_i = 16'd3; do_clear(); mode_i = 2'd3; ticks(5);
    chk("R8 falling count", count_o, 1);
    chk("R8 falling dir", dir_down_o, 1);
    period_i = 16'd0; cycle();
    chk("R5 park in updn count", count_o, 0);
    chk("R5 park in updn dir", dir_down_o, 0);
    period_i = 16'd3; ticks(1);
    chk("R6 restart counts up", count_o, 1);
    chk("R6 restart dir up", dir_down_o, 0);

    // R3: clear resets direction; clear beats write
    do_clear(); ticks(4);
    chk("R3 pre-clear dir down", dir_down_o, 1);
    do_clear();
    chk("R3 clear count", count_o, 0);
    chk("R3 clear dir", dir_down_o, 0);
    clr_i = 1'b1; wr(16'h55); clr_i = 1'b0;
    chk("R3 clear beats write", count_o, 0);

    // R2: write beats tick
    mode_i = 2'd2; tick_i = 1'b1; wr(16'h40); tick_i = 1'b0;
    chk("R2 write beats tick", count_o, 16'h40);

    // R7: count above period
    mode_i = 2'd0; wr(16'd20); period_i = 16'd5; flag_clear(); mode_i = 2'd1;
    ticks(1);
    chk("R7 above period wraps", count_o, 0);
    chk("R7 above period flag", ovf_o, 1);

    // R9: sticky, clear, set wins
    mode_i = 2'd0; repeat (3) cycle();
    chk("R9 flag sticky", ovf_o, 1);
    flag_clear();
    chk("R9 flag cleared", ovf_o, 0);
    period_i = 16'd1; do_clear(); mode_i = 2'd1; ticks(1);
    ovf_clr_i = 1'b1; ticks(1); ovf_clr_i = 1'b0;
    chk("R9 set wins over clear", ovf_o, 1);
    chk("R7 wrap at period one", count_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int period_set[5] = '{1, 2, 3, 5, 7};
  int tri_set[3] = '{1, 3, 4};
endmodule